// File: doc/BRIEF.md
# Program Counter Sequencer with Return Stack

This block keeps the 11-bit program counter of a small 4-bit controller. It decides where execution goes next. The controller strobes `step` once per executed instruction and presents the first instruction byte on `op_a` and, for two-byte forms, the second byte on `op_b`. It also supplies the live condition sources: the accumulator nibble, the addressed memory nibble, the addressed port nibble, the timer flag and the E register. The block decodes the opcode itself. `pc` always holds the address of the instruction about to execute.

The block covers several kinds of control transfer:
- linear advance by one or two bytes;
- absolute jumps;
- a jump that rebuilds the low byte of the PC from E and AC;
- calls into page zero, and full calls;
- subroutine and interrupt returns;
- page-local conditional branches on AC, memory or port bits;
- a timer branch that asks for the timer flag to be cleared.

Return addresses live in a small internal stack. A bank prefix instruction arms a one-shot modifier that flips the top address bit of the next jump or taken branch. An interrupt return also hands the saved carry and zero copies back to the flag logic.

Top module: `pc_sequencer`

## Requirements
- R1: While `rst_n` is low, `pc` is 0, the stack is empty, `bank_pend` is 0, and `stk_err`, `tmf_clr`, `flag_rest`, `cf_rest` and `zf_rest` are 0. All outputs are registered and change only on a rising clock edge.
- R2: With `step` low, `pc` and `bank_pend` hold and the pulse outputs are 0. A stepped opcode that falls in no class below advances `pc` by 1, modulo 2^11.
- R3: JMP has first byte `01101xxx`. It loads `pc` with `{op_a[2:0], op_b}`.
- R4: JPEA, `op_a` = 0xFA, keeps `pc[10:8]` and sets `pc[7:0]` to `{e_reg, acc}`. The bank prefix does not affect it.
- R5: CZP, `op_a` = `1011nnnn`, pushes `pc`+1 and loads `pc` with `{5'b0, nnnn, 2'b00}`.
- R6: CAL has first byte `10101xxx`. It pushes `pc`+2 and loads `pc` with `{op_a[2:0], op_b}`. The bank prefix does not affect it.
- R7: RT (0x62) and RTI (0x22) load `pc` from the most recent stack entry and pop it. After RTI, `flag_rest` pulses for one cycle, and `cf_rest`/`zf_rest` take the values `csf`/`zsf` had during that step.
- R8: Conditional branches are two-byte forms. `op_a[3:2]` picks the source (00 AC, 01 memory nibble, 10 port nibble) and `op_a[1:0]` picks the bit. The prefix 0111 branches when the bit is 1; the prefix 0011 branches when the bit is 0. A taken branch gives `{pc[10:8], op_b}`. A branch that is not taken gives `pc`+2.
- R9: BTM, `op_a` = 0x78, takes priority over the port-bit branch with the same code. When `tmf` is 1, it branches like R8 and pulses `tmf_clr` for one cycle. Otherwise it advances `pc` by 2, with no pulse.
- R10: BANK (0xFD) advances `pc` by 1 and sets `bank_pend`. Any other stepped instruction clears `bank_pend`. While `bank_pend` is set, a JMP or a taken branch (R8 or R9) inverts bit 10 of the new `pc`.
- R11: The stack holds 4 entries. A push when it is full, or a pop when it is empty, pulses `stk_err` for one cycle. A push that overflows is dropped, but the jump still happens. A pop that underflows advances `pc` by 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step | input | 1 | One instruction executes this cycle |
| op_a | input | 8 | First instruction byte |
| op_b | input | 8 | Second instruction byte (two-byte forms) |
| acc | input | 4 | Accumulator nibble |
| mem_nib | input | 4 | Addressed memory nibble |
| port_nib | input | 4 | Addressed port nibble |
| e_reg | input | 4 | E register |
| tmf | input | 1 | Timer flag |
| csf | input | 1 | Saved carry copy |
| zsf | input | 1 | Saved zero copy |
| pc | output | 11 | Address of the next instruction |
| bank_pend | output | 1 | Bank prefix armed for the next instruction |
| tmf_clr | output | 1 | Request to clear the timer flag |
| flag_rest | output | 1 | Carry/zero restore strobe |
| cf_rest | output | 1 | Carry value to restore |
| zf_rest | output | 1 | Zero value to restore |
| stk_err | output | 1 | Stack overflow or underflow pulse |

## Verification
A bad stack pointer or a corrupted stack entry stays hidden until the next return. At that return, `pc` jumps to the wrong address, or `stk_err` rises one step early or late. Deep call chains followed by full unwinds are therefore driven repeatedly. A stale bank bit shows at the next JMP or taken branch, one edge later, as a flipped `pc[10]`. A wrong branch decode shows at once as a `pc` that is off by the whole page offset, or that advanced by 2 where it should have branched.

// File: rtl/pc_sequencer.sv
module pc_sequencer #(
  parameter int DEPTH = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        step,
  input  logic [7:0]  op_a,
  input  logic [7:0]  op_b,
  input  logic [3:0]  acc,
  input  logic [3:0]  mem_nib,
  input  logic [3:0]  port_nib,
  input  logic [3:0]  e_reg,
  input  logic        tmf,
  input  logic        csf,
  input  logic        zsf,
  output logic [10:0] pc,
  output logic        bank_pend,
  output logic        tmf_clr,
  output logic        flag_rest,
  output logic        cf_rest,
  output logic        zf_rest,
  output logic        stk_err
);
  localparam int SPW = $clog2(DEPTH + 1);
  localparam int AW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [10:0]    stk [DEPTH];
  logic [SPW-1:0] sp;

  wire is_jmp  = op_a[7:3] == 5'b01101;
  wire is_cal  = op_a[7:3] == 5'b10101;
  wire is_czp  = op_a[7:4] == 4'b1011;
  wire is_jpea = op_a == 8'hFA;
  wire is_rt   = op_a == 8'h62;
  wire is_rti  = op_a == 8'h22;
  wire is_bank = op_a == 8'hFD;
  wire is_btm  = op_a == 8'h78;
  wire is_brp  = op_a[7:4] == 4'b0111 && op_a[3:2] != 2'b11 && !is_btm;
  wire is_brn  = op_a[7:4] == 4'b0011 && op_a[3:2] != 2'b11;

  wire [3:0] src_nib = (op_a[3:2] == 2'b00) ? acc :
                       (op_a[3:2] == 2'b01) ? mem_nib : port_nib;
  wire       src_bit = src_nib[op_a[1:0]];
  wire       taken   = (is_brp && src_bit) || (is_brn && !src_bit) || (is_btm && tmf);

  wire full  = sp == SPW'(DEPTH);
  wire empty = sp == '0;
  wire [10:0] top = stk[AW'(sp - 1'b1)];

  logic        push, pop;
  logic [10:0] push_val, nxt;

  always_comb begin
    push     = 1'b0;
    pop      = 1'b0;
    push_val = pc + 11'd1;
    nxt      = pc + 11'd1;
    if (is_jmp) begin
      nxt = {op_a[2] ^ bank_pend, op_a[1:0], op_b};
    end else if (is_cal) begin
      push     = 1'b1;
      push_val = pc + 11'd2;
      nxt      = {op_a[2:0], op_b};
    end else if (is_czp) begin
      push = 1'b1;
      nxt  = {5'b0, op_a[3:0], 2'b00};
    end else if (is_jpea) begin
      nxt = {pc[10:8], e_reg, acc};
    end else if (is_rt || is_rti) begin
      pop = 1'b1;
      if (!empty) nxt = top;
    end else if (is_brp || is_brn || is_btm) begin
      nxt = taken ? {pc[10] ^ bank_pend, pc[9:8], op_b} : pc + 11'd2;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc        <= '0;
      sp        <= '0;
      bank_pend <= 1'b0;
      tmf_clr   <= 1'b0;
      flag_rest <= 1'b0;
      cf_rest   <= 1'b0;
      zf_rest   <= 1'b0;
      stk_err   <= 1'b0;
    end else begin
      tmf_clr   <= step && is_btm && tmf;
      flag_rest <= step && is_rti;
      stk_err   <= step && ((push && full) || (pop && empty));
      if (step) begin
        pc        <= nxt;
        bank_pend <= is_bank;
        if (is_rti) begin
          cf_rest <= csf;
          zf_rest <= zsf;
        end
        if (push && !full) begin
          stk[AW'(sp)] <= push_val;
          sp           <= sp + 1'b1;
        end else if (pop && !empty) begin
          sp <= sp - 1'b1;
        end
      end
    end
  end
endmodule

module pc_sequencer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        step,
  input logic [7:0]  op_a,
  input logic [7:0]  op_b,
  input logic [3:0]  acc,
  input logic [3:0]  e_reg,
  input logic        tmf,
  input logic        csf,
  input logic [10:0] pc,
  input logic        bank_pend,
  input logic        tmf_clr,
  input logic        flag_rest,
  input logic        cf_rest
);
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(pc) && !tmf_clr && !flag_rest);

  p_jmp_r3: assert property (@(posedge clk) disable iff (!rst_n)
    step && op_a[7:3] == 5'b01101 && !bank_pend |=> pc == {$past(op_a[2:0]), $past(op_b)});

  p_jpea_r4: assert property (@(posedge clk) disable iff (!rst_n)
    step && op_a == 8'hFA |=> pc == {$past(pc[10:8]), $past(e_reg), $past(acc)});

  p_czp_r5: assert property (@(posedge clk) disable iff (!rst_n)
    step && op_a[7:4] == 4'b1011 |=> pc == {5'b0, $past(op_a[3:0]), 2'b00});

  p_rti_r7: assert property (@(posedge clk) disable iff (!rst_n)
    step && op_a == 8'h22 |=> flag_rest && cf_rest == $past(csf));

  p_btm_r9: assert property (@(posedge clk) disable iff (!rst_n)
    step && op_a == 8'h78 |=> tmf_clr == $past(tmf));

  p_bank_r10: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> bank_pend == ($past(op_a) == 8'hFD));
endmodule

bind pc_sequencer pc_sequencer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .step(step), .op_a(op_a), .op_b(op_b),
  .acc(acc), .e_reg(e_reg), .tmf(tmf), .csf(csf), .pc(pc),
  .bank_pend(bank_pend), .tmf_clr(tmf_clr), .flag_rest(flag_rest), .cf_rest(cf_rest)
);

// File: tb/sim_pc_sequencer.sv
module sim_pc_sequencer;
  localparam int PERIOD = 10;

  logic clk = 0, rst_n = 0, step = 0;
  logic [7:0] op_a = 0, op_b = 0;
  logic [3:0] acc = 0, mem_nib = 0, port_nib = 0, e_reg = 0;
  logic tmf = 0, csf = 0, zsf = 0;
  logic [10:0] pc;
  logic bank_pend, tmf_clr, flag_rest, cf_rest, zf_rest, stk_err;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [10:0] mstk [4];
  int          msp = 0;
  logic [10:0] mpc = 0;
  logic        mbank = 0, mcf = 0, mzf = 0;
  logic        e_err, e_tmf, e_fr;

  always #(PERIOD/2) clk = ~clk;

  pc_sequencer u0 (.*);

  function automatic string tag_of(input logic [7:0] a);
    if (a[7:3] == 5'b01101) return "R3";
    if (a == 8'hFA) return "R4";
    if (a[7:4] == 4'b1011) return "R5";
    if (a[7:3] == 5'b10101) return "R6";
    if (a == 8'h62 || a == 8'h22) return "R7";
    if (a == 8'h78) return "R9";
    if ((a[7:4] == 4'b0111 || a[7:4] == 4'b0011) && a[3:2] != 2'b11) return "R8";
    if (a == 8'hFD) return "R10";
    return "R2";
  endfunction

  function automatic logic cond_bit(input logic [7:0] a);
    logic [3:0] n;
    n = (a[3:2] == 2'b00) ? acc : (a[3:2] == 2'b01) ? mem_nib : port_nib;
    return n[a[1:0]];
  endfunction

  task automatic check(input string req, input int act, input int exp_v);
    checks++;
    if (act != exp_v) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
    end
  endtask

  task automatic model(input logic [7:0] a, input logic [7:0] b);
    logic [10:0] n;
    logic push, pop;
    logic [10:0] pv;
    push = 0; pop = 0; pv = mpc + 11'd1;
    n = mpc + 11'd1;
    e_err = 0; e_tmf = 0; e_fr = 0;
    if (a[7:3] == 5'b01101) n = {a[2] ^ mbank, a[1:0], b};
    else if (a[7:3] == 5'b10101) begin push = 1; pv = mpc + 11'd2; n = {a[2:0], b}; end
    else if (a[7:4] == 4'b1011) begin push = 1; n = {5'b0, a[3:0], 2'b00}; end
    else if (a == 8'hFA) n = {mpc[10:8], e_reg, acc};
    else if (a == 8'h62 || a == 8'h22) begin
      pop = 1;
      if (a == 8'h22) begin e_fr = 1; mcf = csf; mzf = zsf; end
    end else if (a == 8'h78) begin
      if (tmf) begin n = {mpc[10] ^ mbank, mpc[9:8], b}; e_tmf = 1; end
      else n = mpc + 11'd2;
    end else if ((a[7:4] == 4'b0111 || a[7:4] == 4'b0011) && a[3:2] != 2'b11) begin
      if (cond_bit(a) == a[6]) n = {mpc[10] ^ mbank, mpc[9:8], b};
      else n = mpc + 11'd2;
    end
    if (push) begin
      if (msp == 4) e_err = 1;
      else begin mstk[msp] = pv; msp++; end
    end
    if (pop) begin
      if (msp == 0) e_err = 1;
      else begin msp--; n = mstk[msp]; end
    end
    mpc = n;
    mbank = (a == 8'hFD);
  endtask

  task automatic do_step(input logic [7:0] a, input logic [7:0] b);
    string t;
    op_a = a; op_b = b; step = 1;
    t = tag_of(a);
    model(a, b);
    @(posedge clk);
    @(negedge clk);
    step = 0;
    check(t, pc, mpc);
    check("R11", stk_err, e_err);
    check("R10", bank_pend, mbank);
    check("R9", tmf_clr, e_tmf);
    check("R7", flag_rest, e_fr);
    if (e_fr) begin
      check("R7", cf_rest, mcf);
      check("R7", zf_rest, mzf);
    end
  endtask

  task automatic idle(input logic [7:0] a);
    op_a = a; op_b = 8'h5A; step = 0;
    @(posedge clk);
    @(negedge clk);
    check("R2", pc, mpc);
    check("R2", bank_pend, mbank);
    check("R2", {tmf_clr, flag_rest, stk_err}, 0);
  endtask

  task automatic rand_inputs();
    acc = 4'($urandom); mem_nib = 4'($urandom); port_nib = 4'($urandom);
    e_reg = 4'($urandom); tmf = 1'($urandom); csf = 1'($urandom); zsf = 1'($urandom);
  endtask

  function automatic logic [7:0] rand_op();
    case ($urandom % 12)
      0: return {5'b01101, 3'($urandom)};
      1: return 8'hFA;
      2: return {4'b1011, 4'($urandom)};
      3: return {5'b10101, 3'($urandom)};
      4: return 8'h62;
      5: return 8'h22;
      6: return 8'h78;
      7: return {4'b0111, 2'($urandom % 3), 2'($urandom)};
      8: return {4'b0011, 2'($urandom % 3), 2'($urandom)};
      9: return 8'hFD;
      10: return {4'b1000, 4'($urandom)};
      default: return {4'b0100, 4'($urandom)};
    endcase
  endfunction

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1", pc, 0);
    check("R1", {bank_pend, tmf_clr, flag_rest, cf_rest, zf_rest, stk_err}, 0);
    rst_n = 1;
    idle(8'h42);
    do_step(8'h62, 8'h00);
    do_step(8'h84, 8'h00);
    for (int i = 0; i < 5; i++) do_step({4'b1011, 4'(i + 3)}, 8'h00);
    for (int i = 0; i < 5; i++) do_step(8'h62, 8'h00);
    do_step(8'hAB, 8'h3C);
    do_step(8'h40, 8'h00);
    csf = 1; zsf = 0;
    do_step(8'h22, 8'h00);
    do_step(8'hFD, 8'h00);
    idle(8'h6F);
    do_step(8'h6E, 8'h77);
    do_step(8'hFD, 8'h00);
    do_step(8'h41, 8'h00);
    do_step(8'h6E, 8'h77);
    do_step(8'hFA, 8'h00);
    do_step(8'hFD, 8'h00);
    do_step(8'hFA, 8'h00);
    tmf = 0; do_step(8'h78, 8'h11);
    tmf = 1; do_step(8'h78, 8'h22);
    acc = 4'b0100; do_step(8'h72, 8'h90);
    acc = 4'b0100; do_step(8'h32, 8'h91);
    mem_nib = 4'b0001; do_step(8'h34, 8'h55);
    port_nib = 4'b1000; do_step(8'h7B, 8'h66);
    do_step(8'hFD, 8'h00);
    port_nib = 4'b0000; do_step(8'h39, 8'hA0);
    do_step(8'hFD, 8'h00);
    mem_nib = 4'b0000; do_step(8'h75, 8'h33);
    for (int i = 0; i < 3000; i++) begin
      rand_inputs();
      if ($urandom % 10 == 0) idle(rand_op());
      else do_step(rand_op(), 8'($urandom));
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule